// File: doc/BRIEF.md
# Gated CPU Clock Generator

This block derives the clock of a static-core 8-bit CPU from a faster system clock. The high and low halves of each CPU clock period are counted in system-clock ticks. Each half takes its length from a register at the edge that starts it, so software or a sequencer can change the waveform from one CPU cycle to the next. Because the CPU core is static, the generator may stop its clock for an unbounded time without any loss of state. Every stop holds the CPU clock low, and every restart first runs out whatever was left of that low half.

When the CPU starts an I/O access, the generator freezes the CPU clock. An I/O access is an I/O request strobe together with a read, write or machine-cycle-one strobe; the last combination is an interrupt acknowledge. The slow host then services the access for as long as it needs. The host reports completion on a valid/ready pair. For cycles in which the CPU reads the bus (I/O read and interrupt acknowledge), the restart is also held off by a programmable number of ticks, so the data the host drives meets the CPU's setup time. A run input stops the clock, and a single-step mode issues one full CPU period per request.

Top module: `cpuclk_gen`

## Requirements
- R1: A high half lasts max(hi_ticks,1) system ticks and a low half lasts max(lo_ticks,1) ticks. Each half uses the register value present at the edge that begins it, so a change made in the middle of a half affects only the next half of that level.
- R2: During and directly after reset, cpu_clk, stall and done_ready are all 0.
- R3: An I/O access is detected when iorq_n=0 together with at least one of rd_n, wr_n or m1_n at 0; that raises stall. iorq_n=0 alone never raises stall.
- R4: Once stall is raised, cpu_clk falls no later than the end of the current high half (at most max(hi,1) ticks) and then stays low for as long as stall is 1.
- R5: done_ready is 1 only while the stall waits for the host. A completion is taken in the cycle in which done_valid and done_ready are both 1. Before that cycle, the host keeps done_valid asserted.
- R6: After a completion is taken for a read-type stall (rd_n=0 or m1_n=0 at detection), exactly setup_ticks extra ticks pass before the clock advances again. A write stall resumes on the next tick.
- R7: On resume the clock first finishes the low half that was interrupted; a stall entered from a high half therefore shows S+max(lo,1) low ticks after completion. One access stalls only once; detection re-arms when iorq_n returns to 1.
- R8: While run=0 the CPU clock finishes any high half, then holds low; run=1 lets it continue.
- R9: With step_mode=1 the clock holds low between steps. Each step_req pulse yields the rest of the low half, then one full high half, and then holds low again.
- R10: A step_req made while stall is 1 is ignored and does not produce a later pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_ticks | input | HALF_W | High-half length in ticks (0 treated as 1) |
| lo_ticks | input | HALF_W | Low-half length in ticks (0 treated as 1) |
| setup_ticks | input | SETUP_W | Restart hold-off for read-type stalls |
| run | input | 1 | 1 lets the CPU clock run |
| step_mode | input | 1 | 1 selects single-step operation |
| step_req | input | 1 | One-cycle step request |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| m1_n | input | 1 | CPU opcode/acknowledge cycle strobe, active low |
| done_valid | input | 1 | Host has serviced the access (and drives read data) |
| done_ready | output | 1 | Generator is waiting for the host completion |
| stall | output | 1 | An I/O stall is in progress |
| cpu_clk | output | 1 | Clock to the CPU |

## Verification
The checks assume that the CPU strobes are already synchronous to clk. They also assume that the host raises done_valid only while done_ready is 1 and keeps it raised until it is taken. The bench changes all inputs on the falling system-clock edge and asserts done_valid for a single cycle only while a stall is waiting. Half-period registers change only between measurements, except for the one deliberate change in the middle of a half used for R1.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_SETUP = 2'd2
  } stall_st_e;
endpackage

// File: rtl/cg_phase_timer.sv
module cg_phase_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] hi_len,
  input  logic [HALF_W-1:0] lo_len,
  input  logic              hold,
  output logic              clk_out,
  output logic              fall_evt
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] cur_len_q;
  logic              phase_q;
  logic              adv;
  logic              last;
  logic [HALF_W-1:0] hi_eff;
  logic [HALF_W-1:0] lo_eff;

  assign hi_eff   = (hi_len == '0) ? HALF_W'(1) : hi_len;
  assign lo_eff   = (lo_len == '0) ? HALF_W'(1) : lo_len;
  // frozen only while in the low half
  assign adv      = !(hold && !phase_q);
  assign last     = (cnt_q >= cur_len_q - HALF_W'(1));
  assign fall_evt = adv && last && phase_q;
  assign clk_out  = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      cnt_q     <= '0;
      cur_len_q <= HALF_W'(1);
    end else if (adv) begin
      if (last) begin
        phase_q   <= ~phase_q;
        cnt_q     <= '0;
        cur_len_q <= phase_q ? lo_eff : hi_eff;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/cg_stall_ctrl.sv
module cg_stall_ctrl
  import cg_pkg::*;
#(
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iorq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               m1_n,
  input  logic [SETUP_W-1:0] setup_ticks,
  input  logic               done_valid,
  output logic               done_ready,
  output logic               stall
);
  stall_st_e          st_q;
  logic [SETUP_W-1:0] scnt_q;
  logic               served_q;
  logic               rd_type_q;
  logic               access;

  assign access     = !iorq_n && (!rd_n || !wr_n || !m1_n);
  assign stall      = (st_q != ST_IDLE);
  assign done_ready = (st_q == ST_STALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      scnt_q    <= '0;
      served_q  <= 1'b0;
      rd_type_q <= 1'b0;
    end else begin
      if (iorq_n) served_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (access && !served_q) begin
            st_q      <= ST_STALL;
            rd_type_q <= !rd_n || !m1_n;
          end
        end
        ST_STALL: begin
          if (done_valid) begin
            if (rd_type_q && setup_ticks != '0) begin
              st_q   <= ST_SETUP;
              scnt_q <= setup_ticks;
            end else begin
              st_q     <= ST_IDLE;
              served_q <= 1'b1;
            end
          end
        end
        ST_SETUP: begin
          if (scnt_q <= SETUP_W'(1)) begin
            st_q     <= ST_IDLE;
            served_q <= 1'b1;
          end else begin
            scnt_q <= scnt_q - SETUP_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cg_step_gate.sv
module cg_step_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step_mode,
  input  logic step_req,
  input  logic stall,
  input  logic fall_evt,
  output logic gate_hold
);
  logic step_active_q;

  assign gate_hold = !run || (step_mode && !step_active_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_active_q <= 1'b0;
    end else if (!step_mode || (step_active_q && fall_evt)) begin
      step_active_q <= 1'b0;
    end else if (step_req && !stall && !step_active_q) begin
      step_active_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen #(
  parameter int HALF_W  = 8,
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HALF_W-1:0]  hi_ticks,
  input  logic [HALF_W-1:0]  lo_ticks,
  input  logic [SETUP_W-1:0] setup_ticks,
  input  logic               run,
  input  logic               step_mode,
  input  logic               step_req,
  input  logic               iorq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               m1_n,
  input  logic               done_valid,
  output logic               done_ready,
  output logic               stall,
  output logic               cpu_clk
);
  logic gate_hold;
  logic fall_evt;
  logic hold;

  assign hold = stall || gate_hold;

  cg_stall_ctrl #(.SETUP_W(SETUP_W)) stall_i (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .setup_ticks(setup_ticks), .done_valid(done_valid),
    .done_ready(done_ready), .stall(stall)
  );

  cg_step_gate gate_i (
    .clk(clk), .rst_n(rst_n), .run(run), .step_mode(step_mode),
    .step_req(step_req), .stall(stall), .fall_evt(fall_evt),
    .gate_hold(gate_hold)
  );

  cg_phase_timer #(.HALF_W(HALF_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .hi_len(hi_ticks), .lo_len(lo_ticks),
    .hold(hold), .clk_out(cpu_clk), .fall_evt(fall_evt)
  );
endmodule

// File: rtl/cpuclk_gen_chk.sv
module cpuclk_gen_chk #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [HALF_W-1:0] hi_ticks,
  input logic              cpu_clk,
  input logic              stall,
  input logic              done_ready
);
  logic [HALF_W-1:0] hi_q;
  logic [HALF_W:0]   cap_q;
  logic [HALF_W:0]   hrun_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      cap_q  <= '0;
      hrun_q <= '0;
      prev_q <= 1'b0;
    end else begin
      hi_q   <= hi_ticks;
      prev_q <= cpu_clk;
      if (cpu_clk && !prev_q) begin
        cap_q  <= (hi_q == '0) ? (HALF_W+1)'(1) : {1'b0, hi_q};
        hrun_q <= (HALF_W+1)'(1);
      end else if (cpu_clk) begin
        hrun_q <= hrun_q + (HALF_W+1)'(1);
      end
    end
  end

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk && prev_q) |-> (hrun_q < cap_q)); // R1
  AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cpu_clk) |=> !cpu_clk); // R4
  AST_READY_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_ready |-> stall); // R5
  AST_NO_RISE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !$rose(cpu_clk)); // R6
  AST_RUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cpu_clk) |=> !cpu_clk); // R8
endmodule

bind cpuclk_gen cpuclk_gen_chk #(.HALF_W(HALF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .hi_ticks(hi_ticks),
  .cpu_clk(cpu_clk), .stall(stall), .done_ready(done_ready)
);

// File: tb/cpuclk_gen_tb_top.sv
module cpuclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hi_ticks, lo_ticks, setup_ticks;
  logic       run, step_mode, step_req;
  logic       iorq_n, rd_n, wr_n, m1_n, done_valid;
  logic       done_ready, stall, cpu_clk;
  int         nvec = 0;
  int         nbad = 0;

  always #5 clk = ~clk;

  cpuclk_gen #(.HALF_W(8), .SETUP_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .hi_ticks(hi_ticks), .lo_ticks(lo_ticks),
    .setup_ticks(setup_ticks), .run(run), .step_mode(step_mode),
    .step_req(step_req), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .done_valid(done_valid), .done_ready(done_ready),
    .stall(stall), .cpu_clk(cpu_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic v);
    for (int k = 0; k < 1000 && cpu_clk !== v; k++) @(negedge clk);
  endtask

  task automatic count_run(input logic v, output int n);
    n = 0;
    while (cpu_clk === v && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic hold_low(input int cyc, input string req);
    bit ok = 1'b1;
    for (int k = 0; k < cyc; k++) begin
      if (cpu_clk !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    check(ok, req, ok, 1);
  endtask

  task automatic pulse_done();
    done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic pulse_step();
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 2; k++) begin
      wait_level(1'b0);
      wait_level(1'b1);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  // stall entered from a high half, serviced, resume measured
  task automatic io_case(input int kind, input int s, input int hi, input int lo,
                         input string req);
    int n;
    int exp_low;
    hi_ticks = 8'(hi); lo_ticks = 8'(lo); setup_ticks = 8'(s);
    settle();
    iorq_n = 1'b0;
    if (kind == 0) rd_n = 1'b0;
    else if (kind == 1) wr_n = 1'b0;
    else m1_n = 1'b0;
    @(negedge clk);
    check(stall === 1'b1, "R3 stall on access", stall, 1);
    count_run(1'b1, n);
    check(n <= hi, "R4 fall window", n, hi);
    hold_low(15, "R4 held low in stall");
    check(done_ready === 1'b1, "R5 ready while stalled", done_ready, 1);
    pulse_done();
    exp_low = ((kind == 1) ? 0 : s) + lo;
    count_run(1'b0, n);
    check(n == exp_low, {req, " R6 low ticks after completion"}, n, exp_low);
    count_run(1'b1, n);
    check(n == hi, "R7 single stall per access", n, hi);
    check(stall === 1'b0, "R7 no re-stall", stall, 0);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int nh, nl;
    rst_n = 1'b0; hi_ticks = 8'd1; lo_ticks = 8'd1; setup_ticks = 8'd0;
    run = 1'b1; step_mode = 1'b0; step_req = 1'b0;
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1; done_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(cpu_clk === 1'b0, "R2 clock low in reset", cpu_clk, 0);
    check(stall === 1'b0, "R2 stall clear", stall, 0);
    check(done_ready === 1'b0, "R2 ready clear", done_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall === 1'b0 && done_ready === 1'b0, "R2 idle after reset", stall, 0);

    // R1 sweep of both half lengths, zero included
    for (int h = 0; h < 6; h++) begin
      for (int l = 0; l < 6; l++) begin
        hi_ticks = 8'(h); lo_ticks = 8'(l);
        wait_level(1'b0);
        wait_level(1'b1);
        count_run(1'b1, nh);
        count_run(1'b0, nl);
        check(nh == ((h == 0) ? 1 : h), "R1 high half", nh, (h == 0) ? 1 : h);
        check(nl == ((l == 0) ? 1 : l), "R1 low half", nl, (l == 0) ? 1 : l);
      end
    end

    // R1 change in mid half takes effect at the next edge
    hi_ticks = 8'd2; lo_ticks = 8'd2;
    settle();
    hi_ticks = 8'd6;
    count_run(1'b1, nh);
    check(nh == 2, "R1 mid-half change deferred", nh, 2);
    count_run(1'b0, nl);
    count_run(1'b1, nh);
    check(nh == 6, "R1 new value next half", nh, 6);

    // R3 request strobe alone does nothing
    hi_ticks = 8'd2; lo_ticks = 8'd2;
    iorq_n = 1'b0;
    begin
      bit quiet = 1'b1;
      int rises = 0;
      logic prev = cpu_clk;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (stall !== 1'b0) quiet = 1'b0;
        if (cpu_clk && !prev) rises++;
        prev = cpu_clk;
      end
      check(quiet, "R3 iorq alone no stall", quiet, 1);
      check(rises >= 3, "R3 clock keeps running", rises, 3);
    end
    iorq_n = 1'b1;
    @(negedge clk);
    check(done_ready === 1'b0, "R5 no ready when idle", done_ready, 0);

    // R6 read setup sweep, write and acknowledge cycles
    for (int s = 0; s < 4; s++) io_case(0, s, 3, 2, "read");
    io_case(0, 2, 1, 4, "read");
    io_case(1, 3, 3, 2, "write");
    io_case(2, 2, 2, 3, "inta");

    // R8 run stop
    hi_ticks = 8'd3; lo_ticks = 8'd3;
    run = 1'b0;
    repeat (8) @(negedge clk);
    hold_low(20, "R8 run low holds clock");
    run = 1'b1;
    repeat (8) @(negedge clk);
    wait_level(1'b1);
    check(cpu_clk === 1'b1, "R8 run resumes", cpu_clk, 1);

    // R9 single step
    hi_ticks = 8'd3; lo_ticks = 8'd2;
    step_mode = 1'b1;
    repeat (10) @(negedge clk);
    hold_low(20, "R9 step mode holds low");
    pulse_step();
    wait_level(1'b1);
    wait_level(1'b0);
    repeat (3) @(negedge clk);
    pulse_step();
    count_run(1'b0, nl);
    check(nl == 2, "R9 step low remainder", nl, 2);
    count_run(1'b1, nh);
    check(nh == 3, "R9 step one high half", nh, 3);
    hold_low(20, "R9 held after step");

    // R10 step during stall ignored
    iorq_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    check(stall === 1'b1, "R10 stall entered", stall, 1);
    pulse_step();
    repeat (2) @(negedge clk);
    pulse_done();
    iorq_n = 1'b1; wr_n = 1'b1;
    hold_low(20, "R10 step in stall ignored");
    pulse_step();
    count_run(1'b0, nl);
    check(nl == 2, "R10 later step normal", nl, 2);
    count_run(1'b1, nh);
    check(nh == 3, "R10 later step high", nh, 3);
    step_mode = 1'b0;

    summary();
    $finish;
  end
endmodule